// File: doc/BRIEF.md
# Six-Slot Result Bank with Read Modes

The result bank sits between a conversion sequencer and a parallel read port. It stores up to six 12-bit conversion results. Every read hands back one 16-bit word that carries the data, the channel the data belongs to, and a flag that says whether the word is a fresh, unread result. The write side is a single-cycle strobe from the sequencer with a channel number and a 12-bit value. The read side is a single-cycle strobe, and the word appears one clock later.

A 3-bit mode input decides how the six storage slots are used. Values 0 to 5 read that one channel directly. Value 6 steps through the channels in turn on successive reads. Value 7 turns the same six slots into an arrival-ordered queue: results are returned in the order the sequencer delivered them, whatever their channel. A single pair of channels can therefore fill all six places before software reads any of them. A sticky overflow flag records a result that was lost because the queue was full.

Top module: `result_bank`

## Requirements
- R1: `rd_word` is a register. Bit 15 is the valid flag, bits 14:12 are the channel and bits 11:0 are the data. It takes a new value on the clock edge where `rd_en` is high and holds its value on every other edge.
- R2: While `rst` is high at a clock edge, the block clears all six slots, `rd_word`, `overflow`, the step pointer and the queue pointers.
- R3: With `mode` from 0 to 5, a read returns slot `mode` with the channel field equal to `mode`. A write with `wr_chan` from 0 to 5 stores `wr_data` in slot `wr_chan` and marks it valid. A write with `wr_chan` of 6 or 7 changes nothing, in every mode.
- R4: A read clears the valid flag of the slot it returns, so a second read of the same slot gives valid 0 with the same data. If a write hits the slot being read in the same cycle, the read returns the old contents and the slot then holds the new value as valid.
- R5: With `mode` of 6, successive reads return slots 0, 1, 2, 3, 4, 5 and then wrap to 0.
- R6: With `mode` of 7, results come out in the order they were written, and the channel field equals the `wr_chan` of that write. Up to six entries from any mix of channels are kept, for example three of channel 0 and three of channel 1.
- R7: With `mode` of 7, a read of an empty queue returns the all-zero word.
- R8: With `mode` of 7, a write to a queue that already holds six entries is dropped and sets `overflow`, which stays high until reset. This holds even if a read happens in the same cycle: the read is served and the write is still dropped.
- R9: Any change of `mode` from one cycle to the next resets the step pointer, so a read in mode 6 returns slot 0. It also empties the queue. Entering or leaving mode 7 clears all six slots (data and valid) before any read or write of that cycle takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe from the conversion sequencer |
| wr_chan | input | 3 | Channel number of the result being written |
| wr_data | input | 12 | Conversion result |
| mode | input | 3 | 0 to 5: single channel, 6: step through channels, 7: arrival queue |
| rd_en | input | 1 | Read strobe |
| rd_word | output | 16 | Registered read word {valid, channel, data} |
| overflow | output | 1 | Sticky flag: a queue write was lost |

## Verification
The bench targets several corner cases, each of which exposes a specific defect.

- **Read and write to the same slot in one cycle.** A design that let the write win the read would return the new value instead of the old one.
- **Queue that is full while a read happens.** A design that checked fullness after the pop would accept the write and never raise overflow.
- **Step pointer at slot 5.** An off-by-one wrap would show slot 6, or skip slot 0.
- **Mode change in the same cycle as a read.** If pointers or slots were not cleared first, the word would carry a stale channel, stale data or a stale valid flag.

A long mixed run of writes, reads and rare mode changes is compared against a behavioural queue model on every clock.

// File: rtl/result_bank_pkg.sv
package result_bank_pkg;

    localparam int NUM_SLOTS = 6;
    localparam int DATA_W    = 12;
    localparam int CHAN_W    = 3;
    localparam int MODE_W    = 3;
    localparam int PTR_W     = $clog2(NUM_SLOTS);
    localparam int CNT_W     = $clog2(NUM_SLOTS + 1);
    localparam int WORD_W    = 1 + CHAN_W + DATA_W;

    localparam logic [MODE_W-1:0] MODE_STEP  = 3'd6;
    localparam logic [MODE_W-1:0] MODE_QUEUE = 3'd7;

    typedef struct packed {
        logic              valid;
        logic [CHAN_W-1:0] chan;
        logic [DATA_W-1:0] data;
    } rd_word_t;

    typedef enum logic [1:0] {
        RK_SINGLE,
        RK_STEP,
        RK_QUEUE
    } read_kind_e;

    function automatic read_kind_e decode_mode(input logic [MODE_W-1:0] m);
        if (m == MODE_QUEUE)     return RK_QUEUE;
        else if (m == MODE_STEP) return RK_STEP;
        else                     return RK_SINGLE;
    endfunction

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(NUM_SLOTS - 1)) ? '0 : p + 1'b1;
    endfunction

endpackage

// File: rtl/rb_mode_ctrl.sv
module rb_mode_ctrl
    import result_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode,
    input  logic              rd_en,
    output read_kind_e        kind,
    output logic              changed,
    output logic              crossed,
    output logic [PTR_W-1:0]  step_eff,
    output logic [PTR_W-1:0]  step_ptr,
    output logic [MODE_W-1:0] mode_q
);

    always_comb begin
        kind     = decode_mode(mode);
        changed  = (mode != mode_q);
        crossed  = changed && ((mode == MODE_QUEUE) != (mode_q == MODE_QUEUE));
        step_eff = changed ? '0 : step_ptr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= '0;
            step_ptr <= '0;
        end else begin
            mode_q <= mode;
            if (kind == RK_STEP && rd_en) step_ptr <= ptr_next(step_eff);
            else                          step_ptr <= step_eff;
        end
    end

endmodule

// File: rtl/rb_queue_ctrl.sv
module rb_queue_ctrl
    import result_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             restart,
    input  logic             rd_en,
    input  logic             wr_ok,
    output logic [PTR_W-1:0] head,
    output logic [PTR_W-1:0] tail,
    output logic             empty,
    output logic             push,
    output logic             pop,
    output logic [CNT_W-1:0] count,
    output logic             overflow
);

    logic [PTR_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0] count_e;
    logic             full;

    always_comb begin
        head    = restart ? '0 : head_q;
        tail    = restart ? '0 : tail_q;
        count_e = restart ? '0 : count;
        empty   = (count_e == '0);
        full    = (count_e == CNT_W'(NUM_SLOTS));
        pop     = active && rd_en && !empty;
        push    = active && wr_ok && !full;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q   <= '0;
            tail_q   <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            head_q   <= pop  ? ptr_next(head) : head;
            tail_q   <= push ? ptr_next(tail) : tail;
            count    <= count_e + CNT_W'(push) - CNT_W'(pop);
            overflow <= overflow | (active && wr_ok && full);
        end
    end

endmodule

// File: rtl/rb_slot_store.sv
module rb_slot_store
    import result_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              we,
    input  logic [PTR_W-1:0]  wslot,
    input  logic [CHAN_W-1:0] wtag,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclr,
    input  logic [PTR_W-1:0]  rslot,
    output logic              r_valid,
    output logic [CHAN_W-1:0] r_tag,
    output logic [DATA_W-1:0] r_data
);

    logic              valid_a [NUM_SLOTS];
    logic [CHAN_W-1:0] tag_a   [NUM_SLOTS];
    logic [DATA_W-1:0] data_a  [NUM_SLOTS];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                valid_a[g] <= 1'b0;
                tag_a[g]   <= '0;
                data_a[g]  <= '0;
            end else if (we && wslot == PTR_W'(g)) begin
                valid_a[g] <= 1'b1;
                tag_a[g]   <= wtag;
                data_a[g]  <= wdata;
            end else if (clr) begin
                valid_a[g] <= 1'b0;
                tag_a[g]   <= '0;
                data_a[g]  <= '0;
            end else if (rclr && rslot == PTR_W'(g)) begin
                valid_a[g] <= 1'b0;
            end
        end
    end

    always_comb begin
        r_valid = valid_a[rslot];
        r_tag   = tag_a[rslot];
        r_data  = data_a[rslot];
    end

endmodule

// File: rtl/result_bank.sv
module result_bank
    import result_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CHAN_W-1:0] wr_chan,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [MODE_W-1:0] mode,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_word,
    output logic              overflow
);

    read_kind_e        kind;
    logic              changed, crossed;
    logic [PTR_W-1:0]  step_eff, step_ptr;
    logic [MODE_W-1:0] mode_q;
    logic [PTR_W-1:0]  q_head, q_tail;
    logic              q_empty, q_push, q_pop;
    logic [CNT_W-1:0]  q_count;
    logic              wr_ok, is_queue;
    logic [PTR_W-1:0]  reg_slot, rslot, wslot;
    logic              st_we, st_rclr, r_valid;
    logic [CHAN_W-1:0] r_tag;
    logic [DATA_W-1:0] r_data;
    rd_word_t          next_word, word_q;

    assign wr_ok    = wr_en && (wr_chan < CHAN_W'(NUM_SLOTS));
    assign is_queue = (kind == RK_QUEUE);

    rb_mode_ctrl u_mode (
        .clk(clk), .rst(rst), .mode(mode), .rd_en(rd_en),
        .kind(kind), .changed(changed), .crossed(crossed),
        .step_eff(step_eff), .step_ptr(step_ptr), .mode_q(mode_q)
    );

    rb_queue_ctrl u_queue (
        .clk(clk), .rst(rst), .active(is_queue), .restart(changed),
        .rd_en(rd_en), .wr_ok(wr_ok),
        .head(q_head), .tail(q_tail), .empty(q_empty),
        .push(q_push), .pop(q_pop), .count(q_count), .overflow(overflow)
    );

    always_comb begin
        reg_slot = (kind == RK_SINGLE) ? PTR_W'(mode) : step_eff;
        rslot    = is_queue ? q_head : reg_slot;
        wslot    = is_queue ? q_tail : PTR_W'(wr_chan);
        st_we    = is_queue ? q_push : wr_ok;
        st_rclr  = is_queue ? q_pop  : rd_en;
    end

    rb_slot_store u_store (
        .clk(clk), .rst(rst), .clr(crossed),
        .we(st_we), .wslot(wslot), .wtag(wr_chan), .wdata(wr_data),
        .rclr(st_rclr), .rslot(rslot),
        .r_valid(r_valid), .r_tag(r_tag), .r_data(r_data)
    );

    always_comb begin
        next_word = '0;
        if (is_queue) begin
            if (!q_empty) begin
                next_word.valid = 1'b1;
                next_word.chan  = r_tag;
                next_word.data  = r_data;
            end
        end else begin
            next_word.chan  = CHAN_W'(reg_slot);
            next_word.valid = crossed ? 1'b0 : r_valid;
            next_word.data  = crossed ? '0 : r_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        word_q <= '0;
        else if (rd_en) word_q <= next_word;
    end

    assign rd_word = word_q;

endmodule

// File: rtl/result_bank_chk.sv
module result_bank_chk
    import result_bank_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [MODE_W-1:0] mode,
    input logic [MODE_W-1:0] mode_q,
    input logic              rd_en,
    input logic [WORD_W-1:0] rd_word,
    input logic              overflow,
    input logic [PTR_W-1:0]  step_ptr,
    input logic [CNT_W-1:0]  q_count
);

    p_reset_clear_r2: assert property (@(posedge clk)
        rst |=> (rd_word == '0 && !overflow && step_ptr == '0 && q_count == '0));

    p_hold_word_r1: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_word));

    p_step_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_STEP && mode_q == MODE_STEP && rd_en && step_ptr == PTR_W'(NUM_SLOTS - 1))
        |=> step_ptr == '0);

    p_queue_bound_r6: assert property (@(posedge clk) disable iff (rst)
        q_count <= CNT_W'(NUM_SLOTS));

    p_empty_read_r7: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_QUEUE && mode_q == MODE_QUEUE && q_count == '0 && rd_en)
        |=> rd_word == '0);

    p_overflow_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    p_mode_change_r9: assert property (@(posedge clk) disable iff (rst)
        (mode != mode_q && !(rd_en && mode == MODE_STEP)) |=> (step_ptr == '0 && q_count <= CNT_W'(1)));

endmodule

bind result_bank result_bank_chk u_chk (
    .clk(clk), .rst(rst), .mode(mode), .mode_q(mode_q), .rd_en(rd_en),
    .rd_word(rd_word), .overflow(overflow), .step_ptr(step_ptr), .q_count(q_count)
);

// File: tb/result_bank_tb_top.sv
module result_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [2:0]  wr_chan;
    logic [11:0] wr_data;
    logic [2:0]  mode;
    logic        rd_en;
    logic [15:0] rd_word;
    logic        overflow;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    result_bank dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_chan(wr_chan), .wr_data(wr_data),
        .mode(mode), .rd_en(rd_en), .rd_word(rd_word), .overflow(overflow)
    );

    // behavioural reference
    int          m_mode;
    int          m_step;
    logic [11:0] m_data [6];
    bit          m_val  [6];
    logic [14:0] m_q [$];
    logic [15:0] m_word;
    bit          m_ovf;

    task automatic model_clear_slots();
        for (int i = 0; i < 6; i++) begin
            m_data[i] = '0;
            m_val[i]  = 1'b0;
        end
        m_q.delete();
    endtask

    task automatic model_tick(bit r, bit we, int ch, logic [11:0] d, bit re, int md);
        bit   chg, full;
        int   s;
        logic [14:0] e;
        if (r) begin
            model_clear_slots();
            m_mode = 0; m_step = 0; m_word = '0; m_ovf = 1'b0;
            return;
        end
        chg = (md != m_mode);
        if (chg) begin
            m_step = 0;
            if ((md == 7) != (m_mode == 7)) model_clear_slots();
            else m_q.delete();
        end
        if (md == 7) begin
            full = (m_q.size() == 6);
            if (re) begin
                if (m_q.size() > 0) begin
                    e = m_q.pop_front();
                    m_word = {1'b1, e};
                end else m_word = '0;
            end
            if (we && ch < 6) begin
                if (full) m_ovf = 1'b1;
                else m_q.push_back({ch[2:0], d});
            end
        end else begin
            s = (md < 6) ? md : m_step;
            if (re) begin
                m_word = {m_val[s], s[2:0], m_data[s]};
                m_val[s] = 1'b0;
                if (md == 6) m_step = (m_step == 5) ? 0 : m_step + 1;
            end
            if (we && ch < 6) begin
                m_data[ch] = d;
                m_val[ch]  = 1'b1;
            end
        end
        m_mode = md;
    endtask

    task automatic step(bit r, bit we, int ch, logic [11:0] d, bit re, int md, string req);
        rst = r; wr_en = we; wr_chan = ch[2:0]; wr_data = d; rd_en = re; mode = md[2:0];
        @(posedge clk);
        model_tick(r, we, ch, d, re, md);
        @(negedge clk);
        checks++;
        if (rd_word !== m_word) begin
            fails++;
            $display("FAIL %s rd_word actual %h expected %h", req, rd_word, m_word);
        end
        checks++;
        if (overflow !== m_ovf) begin
            fails++;
            $display("FAIL %s overflow actual %0b expected %0b", req, overflow, m_ovf);
        end
    endtask

    task automatic wr(int ch, logic [11:0] d, int md, string req);
        step(0, 1, ch, d, 0, md, req);
    endtask

    task automatic rd(int md, string req);
        step(0, 0, 0, 12'h0, 1, md, req);
    endtask

    task automatic idle(int md, string req);
        step(0, 0, 0, 12'h0, 0, md, req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual expired expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1; wr_en = 0; wr_chan = 0; wr_data = 0; rd_en = 0; mode = 0;
        @(negedge clk);
        // R2: reset state
        repeat (3) step(1, 0, 0, 12'h0, 0, 0, "R2");

        // R3: direct channel writes and reads, out-of-range channel ignored
        for (int c = 0; c < 6; c++) wr(c, 12'h100 + 12'(c), 0, "R3");
        wr(6, 12'hEEE, 0, "R3");
        wr(7, 12'hDDD, 0, "R3");
        for (int c = 0; c < 6; c++) rd(c, "R3");

        // R4: reread gives valid 0, same-cycle read and write
        rd(2, "R4");
        step(0, 1, 3, 12'hABC, 1, 3, "R4");
        rd(3, "R4");
        rd(3, "R4");
        idle(3, "R1");

        // R5: step mode wraps
        for (int c = 0; c < 6; c++) wr(c, 12'h200 + 12'(c), 6, "R5");
        for (int k = 0; k < 8; k++) rd(6, "R5");

        // R9: mode change resets the step pointer
        rd(1, "R9");
        rd(6, "R9");
        rd(6, "R9");
        step(0, 0, 0, 12'h0, 1, 0, "R9");
        rd(6, "R9");

        // R6: queue order with one channel pair filling all places
        for (int k = 0; k < 6; k++) wr(k % 2, 12'h300 + 12'(k), 7, "R6");
        for (int k = 0; k < 6; k++) rd(7, "R6");

        // R7: empty queue read
        rd(7, "R7");
        rd(7, "R7");

        // R8: overflow, and read plus write while full
        for (int k = 0; k < 6; k++) wr(5 - k, 12'h400 + 12'(k), 7, "R8");
        wr(2, 12'h4FF, 7, "R8");
        step(0, 1, 4, 12'h4EE, 1, 7, "R8");
        for (int k = 0; k < 6; k++) rd(7, "R8");
        wr(6, 12'h111, 7, "R3");
        rd(7, "R3");

        // R9: leaving queue mode clears every slot
        wr(1, 12'h555, 7, "R9");
        step(0, 0, 0, 12'h0, 1, 1, "R9");
        rd(1, "R9");
        wr(2, 12'h666, 2, "R9");
        step(0, 1, 0, 12'h777, 1, 7, "R9");
        rd(7, "R9");

        // R1: long mixed run
        begin
            int md = 0;
            for (int k = 0; k < 4000; k++) begin
                if ($urandom_range(0, 39) == 0) md = $urandom_range(0, 7);
                step(0, 1'($urandom_range(0, 1)), $urandom_range(0, 7),
                     12'($urandom_range(0, 4095)), 1'($urandom_range(0, 1)), md, "R1");
            end
        end

        // R2: reset in mid-run
        step(1, 1, 0, 12'h123, 1, 7, "R2");
        idle(0, "R2");
        rd(0, "R2");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule